// File: doc/BRIEF.md
# RF Activity Indicator and Power State Sequencer

This block steps a radio subsystem through its four power modes (active, idle, deep sleep and application sleep). It drives a single warning output, `rf_active`, that tells the host a high-current period is about to begin. All timing is counted in ticks of the 32.768 kHz low-power clock. Each tick arrives as a one-cycle `lp_tick` pulse in the block's clock domain. Radio time is counted in slots of `SLOT_TICKS` ticks. Every duration is a parameter, so a bench can run with short values.

A scheduled radio event is loaded while idle. It carries three fields: ticks until the current rises, a length in slots, and a choice of a two-slot or three-slot warning lead. The output rises when the remaining time falls inside the lead window. It stays high for the whole event and falls when the event ends.

An idle period with nothing scheduled ends in deep sleep. In deep sleep an internal timer wakes the block periodically. On a timer wake the output rises for a fixed lead before the inrush current. A wake through the active-low pin gives no warning at all. A sleep command parks the block in application sleep, which only the pin can end.

The state names are IDLE, ACTIVE, DEEP, WAKE (the timer-wake lead, reported as deep sleep) and APP. The transitions are:
- IDLE→ACTIVE when the event start is reached.
- ACTIVE→IDLE when the event length has run out.
- IDLE→DEEP after the idle timeout.
- IDLE→APP or DEEP→APP on a sleep command.
- DEEP→IDLE on the pin.
- DEEP→WAKE when the sleep period expires.
- WAKE→IDLE when the wake lead expires.
- APP→IDLE on the pin.

Top module: `rf_power_seq`

## Requirements
- R1: After reset `pwr_mode` is 1 (idle) and `rf_active` is low. The `pwr_mode` encoding is 0 active, 1 idle, 2 deep sleep, 3 application sleep.
- R2: With `ev_lead3` low, `rf_active` rises once the ticks left before the event start are at most 2×`SLOT_TICKS`. `pwr_mode` stays 1 meanwhile.
- R3: With `ev_lead3` high, the lead window is 3×`SLOT_TICKS` ticks.
- R4: When the start count reaches zero, `pwr_mode` becomes 0 and `rf_active` is high. After `ev_slots`×`SLOT_TICKS` further ticks, `pwr_mode` returns to 1 with `rf_active` low.
- R5: An event loaded with its start already inside the lead window raises `rf_active` at once.
- R6: After `IDLE_MAX_TICKS` ticks in idle with no event pending, `pwr_mode` becomes 2 with `rf_active` low.
- R7: After `DS_PERIOD_TICKS` ticks in deep sleep, `rf_active` goes high for `WAKE_LEAD_TICKS` ticks while `pwr_mode` still reads 2. Then `pwr_mode` becomes 1 with `rf_active` low.
- R8: `wakeup_n` low in deep sleep returns `pwr_mode` to 1, and `rf_active` never rises on this path.
- R9: `sleep_cmd` in deep sleep, or in idle with no event pending, sets `pwr_mode` to 3 with `rf_active` low. In that mode ticks have no effect, and only `wakeup_n` low returns it to 1. `sleep_cmd` while an event is pending is ignored.
- R10: `ev_valid` is ignored outside idle and while an event is pending. A rejected event never leads to `pwr_mode` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_tick | input | 1 | One-cycle pulse per low-power clock tick |
| ev_valid | input | 1 | Load a radio event (idle only) |
| ev_start | input | CNT_W | Ticks until the event's current rise |
| ev_slots | input | SLOT_W | Event length in slots |
| ev_lead3 | input | 1 | 1 selects a three-slot lead, 0 a two-slot lead |
| wakeup_n | input | 1 | Active-low wake pin, already synchronous |
| sleep_cmd | input | 1 | Host request for application sleep |
| rf_active | output | 1 | High-current warning to the host |
| pwr_mode | output | 2 | Current power mode (encoding in R1) |

## Verification
On every cycle, the checker holds four invariants:
- active mode always shows the warning;
- application sleep never shows it and holds while the pin is high;
- a pin wake from quiet deep sleep reaches idle next cycle with the warning low;
- deep sleep never jumps straight to active.

The exact lead windows need the bench's directed timelines, because they are off by a single tick at their boundaries. The same holds for the event lengths, the idle timeout, the deep-sleep wake period with its warning pulse, and the rejection of late events and sleep commands.

// File: rtl/rfseq_pkg.sv
package rfseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_DEEP,
        ST_WAKE,
        ST_APP
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_ACTIVE = 2'd0,
        MODE_IDLE   = 2'd1,
        MODE_DEEP   = 2'd2,
        MODE_APP    = 2'd3
    } pwr_mode_e;
endpackage

// File: rtl/rfseq_tick_timer.sv
module rfseq_tick_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // done fires on the tick that completes `limit` counted ticks
    assign done = en && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (en)
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/rfseq_ev_tracker.sv
module rfseq_ev_tracker #(
    parameter int CNT_W      = 24,
    parameter int SLOT_W     = 8,
    parameter int SLOT_TICKS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [CNT_W-1:0]  start_in,
    input  logic [SLOT_W-1:0] slots_in,
    input  logic              lead3_in,
    input  logic              go,
    input  logic              run,
    output logic              pend,
    output logic              start_due,
    output logic              in_lead,
    output logic              len_done
);
    localparam logic [CNT_W-1:0] SLOT_V  = CNT_W'(SLOT_TICKS);
    localparam logic [CNT_W-1:0] LEAD2_V = SLOT_V * CNT_W'(2);
    localparam logic [CNT_W-1:0] LEAD3_V = SLOT_V * CNT_W'(3);

    logic             pend_q;
    logic [CNT_W-1:0] start_q, len_q, lead_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            start_q <= '0;
            len_q   <= '0;
            lead_q  <= '0;
        end else if (load) begin
            pend_q  <= 1'b1;
            start_q <= start_in;
            len_q   <= CNT_W'(slots_in) * SLOT_V;
            lead_q  <= lead3_in ? LEAD3_V : LEAD2_V;
        end else begin
            if (go)
                pend_q <= 1'b0;
            if (tick && pend_q && start_q != '0)
                start_q <= start_q - CNT_W'(1);
            if (tick && run && len_q != '0)
                len_q <= len_q - CNT_W'(1);
        end
    end

    assign pend      = pend_q;
    assign start_due = pend_q && (start_q == '0);
    assign in_lead   = pend_q && (start_q <= lead_q);
    assign len_done  = (len_q == '0);
endmodule

// File: rtl/rf_power_seq.sv
module rf_power_seq #(
    parameter int CNT_W           = 24,
    parameter int SLOT_W          = 8,
    parameter int SLOT_TICKS      = 20,
    parameter int IDLE_MAX_TICKS  = 1311,
    parameter int DS_PERIOD_TICKS = 1310720,
    parameter int WAKE_LEAD_TICKS = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_tick,
    input  logic              ev_valid,
    input  logic [CNT_W-1:0]  ev_start,
    input  logic [SLOT_W-1:0] ev_slots,
    input  logic              ev_lead3,
    input  logic              wakeup_n,
    input  logic              sleep_cmd,
    output logic              rf_active,
    output logic [1:0]        pwr_mode
);
    import rfseq_pkg::*;

    localparam logic [CNT_W-1:0] IDLE_LIM = CNT_W'(IDLE_MAX_TICKS);
    localparam logic [CNT_W-1:0] DS_LIM   = CNT_W'(DS_PERIOD_TICKS);
    localparam logic [CNT_W-1:0] WL_LIM   = CNT_W'(WAKE_LEAD_TICKS);

    seq_state_e       state_q, state_d;
    logic             pend, start_due, in_lead, len_done;
    logic             counting, tmr_clr, tmr_en, tmr_done;
    logic             ev_load, ev_go;
    logic [CNT_W-1:0] tmr_limit;

    rfseq_ev_tracker #(
        .CNT_W(CNT_W), .SLOT_W(SLOT_W), .SLOT_TICKS(SLOT_TICKS)
    ) u_ev (
        .clk(clk), .rst_n(rst_n), .tick(lp_tick),
        .load(ev_load), .start_in(ev_start), .slots_in(ev_slots),
        .lead3_in(ev_lead3), .go(ev_go), .run(state_q == ST_ACTIVE),
        .pend(pend), .start_due(start_due), .in_lead(in_lead),
        .len_done(len_done)
    );

    rfseq_tick_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en),
        .limit(tmr_limit), .done(tmr_done)
    );

    // One shared tick counter serves the idle timeout, the sleep period
    // and the wake lead; it restarts on every state change.
    always_comb begin
        counting  = 1'b0;
        tmr_limit = IDLE_LIM;
        unique case (state_q)
            ST_IDLE:   counting = !pend;
            ST_DEEP:   begin counting = 1'b1; tmr_limit = DS_LIM; end
            ST_WAKE:   begin counting = 1'b1; tmr_limit = WL_LIM; end
            ST_ACTIVE: counting = 1'b0;
            ST_APP:    counting = 1'b0;
        endcase
    end

    assign tmr_en  = lp_tick && counting;
    assign tmr_clr = (state_d != state_q) || !counting;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sleep_cmd && !pend)  state_d = ST_APP;
                else if (start_due)      state_d = ST_ACTIVE;
                else if (tmr_done)       state_d = ST_DEEP;
            end
            ST_ACTIVE: if (len_done)     state_d = ST_IDLE;
            ST_DEEP: begin
                if (!wakeup_n)           state_d = ST_IDLE;
                else if (sleep_cmd)      state_d = ST_APP;
                else if (tmr_done)       state_d = ST_WAKE;
            end
            ST_WAKE: if (tmr_done)       state_d = ST_IDLE;
            ST_APP:  if (!wakeup_n)      state_d = ST_IDLE;
        endcase
    end

    assign ev_load = (state_q == ST_IDLE) && (state_d == ST_IDLE) && ev_valid && !pend;
    assign ev_go   = (state_q == ST_IDLE) && (state_d == ST_ACTIVE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rf_active = 1'b0;
        pwr_mode  = MODE_IDLE;
        unique case (state_q)
            ST_IDLE:   begin rf_active = in_lead; pwr_mode = MODE_IDLE;   end
            ST_ACTIVE: begin rf_active = 1'b1;    pwr_mode = MODE_ACTIVE; end
            ST_DEEP:   begin rf_active = 1'b0;    pwr_mode = MODE_DEEP;   end
            ST_WAKE:   begin rf_active = 1'b1;    pwr_mode = MODE_DEEP;   end
            ST_APP:    begin rf_active = 1'b0;    pwr_mode = MODE_APP;    end
        endcase
    end
endmodule

// File: rtl/rf_power_seq_chk.sv
module rf_power_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wakeup_n,
    input logic       rf_active,
    input logic [1:0] pwr_mode
);
    // R4
    active_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'd0) |-> rf_active);

    // R9
    app_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'd3) |-> !rf_active);

    // R9
    app_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'd3 && wakeup_n) |=> (pwr_mode == 2'd3));

    // R8
    pin_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'd2 && !rf_active && !wakeup_n) |=> (pwr_mode == 2'd1 && !rf_active));

    // R10
    deep_no_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'd2) |=> (pwr_mode != 2'd0));
endmodule

bind rf_power_seq rf_power_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wakeup_n(wakeup_n),
    .rf_active(rf_active), .pwr_mode(pwr_mode)
);

// File: tb/sim_rf_power_seq.sv
module sim_rf_power_seq;
    localparam int CNT_W = 24;
    localparam int SLOT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_tick = 1'b0, ev_valid = 1'b0, ev_lead3 = 1'b0;
    logic wakeup_n = 1'b1, sleep_cmd = 1'b0;
    logic [CNT_W-1:0] ev_start = '0;
    logic [SLOT_W-1:0] ev_slots = '0;
    logic rf_active;
    logic [1:0] pwr_mode;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic       exp_rf_q[$];
    logic [1:0] exp_md_q[$];
    string      tag_q[$];
    event       smp;

    always #4 clk = ~clk;

    rf_power_seq #(
        .CNT_W(CNT_W), .SLOT_W(SLOT_W), .SLOT_TICKS(4),
        .IDLE_MAX_TICKS(10), .DS_PERIOD_TICKS(20), .WAKE_LEAD_TICKS(3)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .lp_tick(lp_tick), .ev_valid(ev_valid),
        .ev_start(ev_start), .ev_slots(ev_slots), .ev_lead3(ev_lead3),
        .wakeup_n(wakeup_n), .sleep_cmd(sleep_cmd),
        .rf_active(rf_active), .pwr_mode(pwr_mode)
    );

    // monitor: pops one expectation per sample event and compares
    initial begin
        forever begin
            @(smp);
            while (exp_rf_q.size() > 0) begin
                logic       e_rf;
                logic [1:0] e_md;
                string      t;
                e_rf = exp_rf_q.pop_front();
                e_md = exp_md_q.pop_front();
                t    = tag_q.pop_front();
                checks++;
                if (rf_active !== e_rf || pwr_mode !== e_md) begin
                    errors++;
                    $display("FAIL %s: rf_active=%0b pwr_mode=%0d expected rf_active=%0b pwr_mode=%0d",
                             t, rf_active, pwr_mode, e_rf, e_md);
                end
            end
        end
    end

    task automatic expect_out(input logic rf, input logic [1:0] md, input string tag);
        exp_rf_q.push_back(rf);
        exp_md_q.push_back(md);
        tag_q.push_back(tag);
        -> smp;
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) lp_tick = 1'b1;
            @(negedge clk) lp_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic load_ev(input int st, input int sl, input logic l3);
        @(negedge clk);
        ev_valid = 1'b1;
        ev_start = CNT_W'(st);
        ev_slots = SLOT_W'(sl);
        ev_lead3 = l3;
        @(negedge clk) ev_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_sleep();
        @(negedge clk) sleep_cmd = 1'b1;
        @(negedge clk) sleep_cmd = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pin_wake(input string tag);
        @(negedge clk) wakeup_n = 1'b0;
        @(negedge clk);
        expect_out(1'b0, 2'd1, tag);
        @(negedge clk) wakeup_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(1'b0, 2'd1, "R1 reset state");

        // two-slot lead: start 12, lead window 8
        load_ev(12, 2, 1'b0);
        expect_out(1'b0, 2'd1, "R2 just loaded");
        ticks(3);  expect_out(1'b0, 2'd1, "R2 one tick before lead");
        ticks(1);  expect_out(1'b1, 2'd1, "R2 lead entered");
        ticks(7);  expect_out(1'b1, 2'd1, "R2 last lead tick");
        ticks(1);  expect_out(1'b1, 2'd0, "R4 event started");
        ticks(7);  expect_out(1'b1, 2'd0, "R4 event still running");
        ticks(1);  expect_out(1'b0, 2'd1, "R4 event ended");

        // three-slot lead: start 20, lead window 12
        load_ev(20, 1, 1'b1);
        ticks(7);  expect_out(1'b0, 2'd1, "R3 before lead");
        ticks(1);  expect_out(1'b1, 2'd1, "R3 lead entered");
        ticks(12); expect_out(1'b1, 2'd0, "R3 event started");
        ticks(4);  expect_out(0, 2'd1, "R4 one-slot event ended");

        // start already inside the window
        load_ev(5, 1, 1'b0);
        expect_out(1'b1, 2'd1, "R5 immediate warning");
        ticks(5);  expect_out(1'b1, 2'd0, "R5 event started");
        ticks(4);  expect_out(1'b0, 2'd1, "R4 end after short start");

        // idle timeout into deep sleep
        ticks(9);  expect_out(1'b0, 2'd1, "R6 before idle timeout");
        ticks(1);  expect_out(1'b0, 2'd2, "R6 entered deep sleep");

        // timer wake with warning lead
        ticks(19); expect_out(1'b0, 2'd2, "R7 before sleep period ends");
        ticks(1);  expect_out(1'b1, 2'd2, "R7 wake lead started");
        ticks(2);  expect_out(1'b1, 2'd2, "R7 wake lead held");
        ticks(1);  expect_out(1'b0, 2'd1, "R7 back to idle");

        // event ignored in deep sleep, then pin wake
        ticks(10); expect_out(1'b0, 2'd2, "R6 deep sleep again");
        load_ev(0, 1, 1'b0);
        expect_out(1'b0, 2'd2, "R10 event ignored in deep sleep");
        pin_wake("R8 pin wake without warning");
        ticks(2);  expect_out(1'b0, 2'd1, "R10 no stale event after wake");

        // application sleep from idle
        pulse_sleep();
        expect_out(1'b0, 2'd3, "R9 app sleep from idle");
        ticks(25); expect_out(1'b0, 2'd3, "R9 ticks do not wake app sleep");
        load_ev(0, 1, 1'b0);
        expect_out(1'b0, 2'd3, "R10 event ignored in app sleep");
        pin_wake("R9 pin leaves app sleep");

        // application sleep from deep sleep
        ticks(10); expect_out(1'b0, 2'd2, "R6 deep before sleep command");
        pulse_sleep();
        expect_out(1'b0, 2'd3, "R9 app sleep from deep sleep");
        pin_wake("R9 pin leaves app sleep again");

        // sleep and second event rejected while an event is pending
        load_ev(30, 1, 1'b0);
        pulse_sleep();
        expect_out(1'b0, 2'd1, "R9 sleep ignored while pending");
        load_ev(0, 1, 1'b0);
        expect_out(1'b0, 2'd1, "R10 second event ignored while pending");
        ticks(30); expect_out(1'b1, 2'd0, "R4 pending event started");
        ticks(4);  expect_out(1'b0, 2'd1, "R4 pending event ended");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule